// File: doc/BRIEF.md
# Sequential GF(2) Parity Generator

This block produces the parity part of a systematic block codeword. The generator matrix has the form identity followed by a parity section, so the message bits pass through unchanged and only the parity columns need to be computed. Each parity bit is the GF(2) dot product of the message with one coefficient column. That is a bitwise AND followed by an XOR reduction tree.

A one-cycle start pulse captures a K-bit message. The block then issues LANES parity bits per clock, one group after another, reading LANES coefficient columns per cycle from an internal constant table. Storage and logic scale with LANES, and throughput scales with it too. A valid flag marks each issued group and a last flag marks the final one. When the parity length is not a multiple of LANES, a lane mask marks which bits of the final group are real. A new message can be accepted while the final group of the previous one is on the outputs, so encodings can run back to back.

Top module: `pgen_top`

## Requirements
- R1: While reset is held and right after it, valid_o, last_o, busy_o, par_o and lane_mask_o are all zero.
- R2: A start_i pulse sampled while busy_o is low captures msg_i. Group 0 of the parity is presented, with valid_o high, in the cycle after that clock edge.
- R3: In group g, lane l carries parity column j = g*LANES + l. Its value is the XOR over message bits i of msg[i] AND c(i,j), where c(i,j) = 1 exactly when (5*i + 3*j + i*j) mod 7 is less than 3.
- R4: Exactly ceil(NPAR/LANES) groups are issued on consecutive cycles in increasing group order. last_o is high only with the final group. Without a new start, valid_o drops in the following cycle.
- R5: lane_mask_o bit l is high exactly when valid_o is high and g*LANES + l < NPAR. Lanes whose mask bit is low output zero.
- R6: A start_i pulse sampled while busy_o is high is ignored. The groups still being issued belong to the earlier message.
- R7: While valid_o is low, par_o and lane_mask_o are zero and last_o is low.
- R8: busy_o is high while a group other than the final one is being issued. A start sampled during the final group begins the next message's group 0 in the very next cycle.
- R9: Changes on msg_i after capture have no effect on the groups being issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Capture msg_i and begin a parity sequence |
| msg_i | input | K | Message vector, bit i is message bit i |
| busy_o | output | 1 | Sequence in progress, start not accepted |
| par_o | output | LANES | Parity bits of the current group, bit l is lane l |
| valid_o | output | 1 | A parity group is on par_o |
| last_o | output | 1 | The current group is the final one |
| lane_mask_o | output | LANES | Lanes of the current group that hold real parity columns |

## Verification
The bench builds the block with K=32, NPAR=11 and LANES=4. This gives three groups per message, and the final group uses only three of its four lanes. That brings the partial lane mask and the zeroing of unused lanes within reach, along with the full-mask middle groups. A 32-bit message is wide enough that the XOR trees see all-zero, all-one, single-end-bit and mixed patterns. Three groups leave room to inject a start pulse and a changed message in the middle of a sequence, and to chain a new start onto the final group.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

    // generator coefficient for message bit i and parity column j
    function automatic logic coef_bit(input int i, input int j);
        return ((5 * i + 3 * j + i * j) % 7) < 3;
    endfunction

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/pgen_coef_rom.sv
module pgen_coef_rom
    import pgen_pkg::*;
#(
    parameter int K     = 32,
    parameter int NPAR  = 11,
    parameter int LANES = 4,
    parameter int GW    = 2
) (
    input  logic [GW-1:0]               grp_i,
    output logic [LANES-1:0][K-1:0]     col_o
);
    localparam int NCOL = (2 ** GW) * LANES;

    function automatic logic [NCOL-1:0][K-1:0] build_table();
        logic [NCOL-1:0][K-1:0] t;
        for (int j = 0; j < NCOL; j++) begin
            for (int i = 0; i < K; i++) begin
                t[j][i] = (j < NPAR) ? coef_bit(i, j) : 1'b0;
            end
        end
        return t;
    endfunction

    localparam logic [NCOL-1:0][K-1:0] TABLE = build_table();

    for (genvar l = 0; l < LANES; l++) begin : g_col
        assign col_o[l] = TABLE[int'(grp_i) * LANES + l];
    end

endmodule

// File: rtl/pgen_lane.sv
module pgen_lane #(
    parameter int K = 32
) (
    input  logic [K-1:0] msg_i,
    input  logic [K-1:0] col_i,
    input  logic         en_i,
    output logic         bit_o
);
    // AND stage then balanced XOR reduction
    assign bit_o = en_i & (^(msg_i & col_i));
endmodule

// File: rtl/pgen_top.sv
module pgen_top
    import pgen_pkg::*;
#(
    parameter int K     = 32,
    parameter int NPAR  = 11,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [K-1:0]     msg_i,
    output logic             busy_o,
    output logic [LANES-1:0] par_o,
    output logic             valid_o,
    output logic             last_o,
    output logic [LANES-1:0] lane_mask_o
);
    localparam int NGRP = ceil_div(NPAR, LANES);
    localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;

    typedef struct packed {
        logic          active;
        logic [GW-1:0] grp;
        logic [K-1:0]  msg;
    } state_t;

    state_t st_d, st_q;
    logic   at_last;
    logic [LANES-1:0]        lane_en;
    logic [LANES-1:0][K-1:0] cols;

    always_comb begin
        st_d    = st_q;
        at_last = st_q.active && (st_q.grp == GW'(NGRP - 1));
        if (st_q.active) begin
            if (at_last) st_d.active = 1'b0;
            else         st_d.grp    = st_q.grp + 1'b1;
        end
        if (start_i && !(st_q.active && !at_last)) begin
            st_d.active = 1'b1;
            st_d.grp    = '0;
            st_d.msg    = msg_i;
        end
        for (int l = 0; l < LANES; l++) begin
            lane_en[l] = st_q.active && ((int'(st_q.grp) * LANES + l) < NPAR);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pgen_coef_rom #(.K(K), .NPAR(NPAR), .LANES(LANES), .GW(GW)) u_rom (
        .grp_i (st_q.grp),
        .col_o (cols)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        pgen_lane #(.K(K)) u_lane (
            .msg_i (st_q.msg),
            .col_i (cols[l]),
            .en_i  (lane_en[l]),
            .bit_o (par_o[l])
        );
    end

    assign valid_o     = st_q.active;
    assign last_o      = at_last;
    assign busy_o      = st_q.active && !at_last;
    assign lane_mask_o = lane_en;

endmodule

// File: rtl/pgen_chk.sv
module pgen_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic [LANES-1:0] par_o,
    input logic             valid_o,
    input logic             last_o,
    input logic [LANES-1:0] lane_mask_o
);
    AST_START_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (valid_o && !busy_o ? 1'b1 : valid_o)); // R2
    AST_GROUPS_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o); // R4
    AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o); // R4
    AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R7
    AST_UNMASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (par_o & ~lane_mask_o) == '0); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (par_o == '0 && lane_mask_o == '0)); // R7
    AST_MID_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |-> (&lane_mask_o)); // R5
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> valid_o); // R6
endmodule

bind pgen_top pgen_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .par_o       (par_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .lane_mask_o (lane_mask_o)
);

// File: tb/sim_pgen_top.sv
module sim_pgen_top;
    localparam int PERIOD = 10;
    localparam int K      = 32;
    localparam int NPAR   = 11;
    localparam int LANES  = 4;
    localparam int NGRP   = (NPAR + LANES - 1) / LANES;

    // bit 32: disturb the run mid-sequence with a start and a new msg_i
    localparam logic [32:0] VEC [8] = '{
        {1'b0, 32'h0000_0000}, {1'b0, 32'hFFFF_FFFF},
        {1'b0, 32'h0000_0001}, {1'b0, 32'h8000_0000},
        {1'b1, 32'hA5A5_F00F}, {1'b0, 32'h1234_5678},
        {1'b1, 32'h0F0F_3C3C}, {1'b0, 32'hDEAD_BEEF}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [K-1:0]     msg_i = '0;
    logic             busy_o;
    logic [LANES-1:0] par_o;
    logic             valid_o;
    logic             last_o;
    logic [LANES-1:0] lane_mask_o;

    int total = 0;
    int bad   = 0;

    always #(PERIOD / 2) clk = ~clk;

    pgen_top #(.K(K), .NPAR(NPAR), .LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .msg_i(msg_i),
        .busy_o(busy_o), .par_o(par_o), .valid_o(valid_o),
        .last_o(last_o), .lane_mask_o(lane_mask_o)
    );

    function automatic logic [LANES-1:0] exp_par(input logic [K-1:0] m, input int g);
        logic [LANES-1:0] r = '0;
        for (int l = 0; l < LANES; l++) begin
            int j = g * LANES + l;
            if (j < NPAR)
                for (int i = 0; i < K; i++)
                    if (((5 * i + 3 * j + i * j) % 7) < 3) r[l] ^= m[i];
        end
        return r;
    endfunction

    function automatic logic [LANES-1:0] exp_mask(input int g);
        logic [LANES-1:0] r = '0;
        for (int l = 0; l < LANES; l++) r[l] = (g * LANES + l) < NPAR;
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // check one group at a negedge: outputs, flags and mask
    task automatic chk_group(input logic [K-1:0] m, input int g);
        chk("R3", $sformatf("par grp%0d", g), 32'(par_o), 32'(exp_par(m, g)));
        chk("R4", $sformatf("valid grp%0d", g), 32'(valid_o), 32'd1);
        chk("R4", $sformatf("last grp%0d", g), 32'(last_o), 32'(g == NGRP - 1));
        chk("R5", $sformatf("mask grp%0d", g), 32'(lane_mask_o), 32'(exp_mask(g)));
        chk("R8", $sformatf("busy grp%0d", g), 32'(busy_o), 32'(g != NGRP - 1));
    endtask

    initial begin
        #(PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [K-1:0] m;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", 32'(valid_o), 32'd0);
        chk("R1", "par in reset", 32'(par_o), 32'd0);
        chk("R1", "busy in reset", 32'(busy_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "mask after reset", 32'(lane_mask_o), 32'd0);
        chk("R7", "idle last", 32'(last_o), 32'd0);

        // vector walk: R2, R3, R4, R5, R6, R9
        for (int v = 0; v < 8; v++) begin
            m = VEC[v][31:0];
            start_i = 1'b1;
            msg_i   = m;
            @(negedge clk);
            start_i = 1'b0;
            for (int g = 0; g < NGRP; g++) begin
                chk_group(m, g);   // R2 at g==0
                if (VEC[v][32] && g == 0) begin
                    start_i = 1'b1;   // R6: ignored while busy
                    msg_i   = ~m;     // R9: no effect after capture
                end
                @(negedge clk);
                start_i = 1'b0;
            end
            chk("R4", "valid after last", 32'(valid_o), 32'd0);
            chk("R7", "par after last", 32'(par_o), 32'd0);
            @(negedge clk);
        end

        // R8: back-to-back start during the final group
        m = 32'hC001_D00D;
        start_i = 1'b1;
        msg_i   = m;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        start_i = 1'b1;
        msg_i   = 32'h5555_AAAA;
        @(negedge clk);
        start_i = 1'b0;
        msg_i   = '0;
        chk("R8", "chained grp0 par", 32'(par_o), 32'(exp_par(32'h5555_AAAA, 0)));
        chk("R8", "chained grp0 valid", 32'(valid_o), 32'd1);
        chk("R8", "chained grp0 last", 32'(last_o), 32'd0);
        @(negedge clk);
        @(negedge clk);
        chk("R8", "chained final par", 32'(par_o), 32'(exp_par(32'h5555_AAAA, NGRP - 1)));

        // R7: idle with no start stays quiet
        repeat (3) @(negedge clk);
        chk("R7", "idle valid", 32'(valid_o), 32'd0);
        chk("R7", "idle par", 32'(par_o), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule